// File: doc/BRIEF.md
# Internal Data Address Mapper

This block turns the internal-data accesses of a small 8-bit core into physical locations. It owns a 128-byte data RAM, the stack pointer and a forwarding port toward the special function register (SFR) bus. Each request carries one of four access kinds: a general register number, a bit address, a byte address marked direct or indirect, or a stack push/pop. From these inputs and the two bank-select bits of the core's status word, the block picks one of three targets: a RAM byte, a bit inside a RAM byte, or the SFR bus. It also flags accesses that have no valid target.

The core issues at most one request per cycle. A RAM read returns its data in the cycle after the request. A RAM write, including a single-bit read-modify-write, has taken effect by the time the next request is presented. SFR accesses leave through a registered strobe and carry no response.

The request kind is encoded as 00 = register, 01 = bit, 10 = byte, 11 = stack. For a stack request, `req_write`=1 means push and 0 means pop. For a bit write, the value comes from `req_wdata[0]`.

Top module: `idata_mapper`

## Requirements
- R1: A register request maps to RAM byte status_i[4:3]×8 + req_addr[2:0]. For example, R4 with bits 4:3 = 11 maps to 1Ch, and the other status bits have no effect.
- R2: The bank is sampled on every request. A bank change between two back-to-back register requests sends the second request to the new bank.
- R3: A bit read of address b (b < 80h) returns bit b[2:0] of RAM byte 20h + b[6:3] in rsp_data[0], with rsp_data[7:1] = 0, in the cycle after the request.
- R4: A bit write changes only bit b[2:0] of byte 20h + b[6:3], taking the value of req_wdata[0]. Bit writes to the same byte on consecutive cycles all take effect.
- R5: A direct byte access to 00h–7Fh reads or writes that RAM byte. The response (rsp_valid=1, rsp_err=0, data) appears in the cycle after the request.
- R6: A direct byte access to 80h–FFh gives sfr_stb=1 one cycle later, with sfr_addr, sfr_wdata and sfr_we taken from the request. It gives no rsp_valid and leaves RAM unchanged.
- R7: An indirect byte access never reaches the SFR bus. An indirect address at or above the RAM size gives rsp_valid=1 and rsp_err=1, and no RAM byte is written.
- R8: A bit request with req_addr[7]=1 gives rsp_err=1 and writes nothing.
- R9: sp_o resets to 07h. A push writes to sp_o+1 and increments sp_o, so the first push lands at 08h. A pop returns the byte at sp_o and then decrements sp_o.
- R10: Every request gives, in the next cycle, exactly one of rsp_valid or sfr_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 register, 01 bit, 10 byte, 11 stack |
| req_write | input | 1 | Write (push for stack) |
| req_indirect | input | 1 | Byte access is indirect |
| req_addr | input | 8 | Register number, bit address or byte address |
| req_wdata | input | 8 | Write data (bit value in bit 0) |
| status_i | input | 8 | Core status word; bits 4:3 select the bank |
| rsp_valid | output | 1 | RAM-side response valid |
| rsp_err | output | 1 | Access had no valid target |
| rsp_data | output | 8 | Read data |
| sfr_stb | output | 1 | SFR bus access strobe |
| sfr_we | output | 1 | SFR write |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sp_o | output | 8 | Current stack pointer |

## Verification
The bench builds the block with its default parameters: 128 RAM bytes, four banks of eight registers, the bit window at 20h and a stack reset of 07h. With these values the interesting edges can be reached directly. The last register of the last bank is 1Fh and the last bit window byte is 2Fh. An indirect address of 80h and above is the invalid case. The first push, from 07h to 08h, sits just above bank 0. The same 7-bit offset is also hit from both the RAM half and the SFR half, to show that the two halves stay apart.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    K_REG   = 2'b00,
    K_BIT   = 2'b01,
    K_BYTE  = 2'b10,
    K_STACK = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    T_RAM = 2'b00,
    T_SFR = 2'b01,
    T_ERR = 2'b10
  } tgt_e;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter int         RAM_BYTES = 128,
  parameter int         BANKS     = 4,
  parameter int         BANK_REGS = 8,
  parameter int         BANK_LSB  = 3,
  parameter logic [7:0] BIT_BASE  = 8'h20
) (
  input  kind_e                          kind,
  input  logic                           indirect,
  input  logic                           push,
  input  logic [7:0]                     addr,
  input  logic [7:0]                     status,
  input  logic [7:0]                     sp,
  output tgt_e                           tgt,
  output logic [$clog2(RAM_BYTES)-1:0]   ram_idx,
  output logic [2:0]                     bit_pos,
  output logic                           is_bit
);
  localparam int         AW     = $clog2(RAM_BYTES);
  localparam int         BANK_W = $clog2(BANKS);
  localparam int         REG_W  = $clog2(BANK_REGS);
  localparam logic [8:0] LIM    = 9'(RAM_BYTES);

  logic [7:0] idx;
  logic       unused_idx;

  always_comb begin
    idx     = addr;
    tgt     = T_RAM;
    bit_pos = addr[2:0];
    is_bit  = 1'b0;
    unique case (kind)
      K_REG:   idx = 8'({status[BANK_LSB +: BANK_W], addr[REG_W-1:0]});
      K_BIT: begin
        is_bit = 1'b1;
        idx    = BIT_BASE + {4'b0000, addr[6:3]};
        if (addr[7]) tgt = T_ERR;
      end
      K_BYTE:  if (!indirect && addr[7]) tgt = T_SFR;
      K_STACK: idx = push ? sp + 8'd1 : sp;
    endcase
    if (tgt == T_RAM && {1'b0, idx} >= LIM) tgt = T_ERR;
  end

  assign ram_idx    = idx[AW-1:0];
  assign unused_idx = ^idx;
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/idm_stack.sv
module idm_stack #(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       pop,
  output logic [7:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_RESET;
    else if (push) sp <= sp + 8'd1;
    else if (pop)  sp <= sp - 8'd1;
  end

  p_sp_push_r9: assert property (@(posedge clk) disable iff (rst)
    push |=> sp == $past(sp) + 8'd1);
  p_sp_pop_r9: assert property (@(posedge clk) disable iff (rst)
    pop |=> sp == $past(sp) - 8'd1);
endmodule

// File: rtl/idata_mapper.sv
module idata_mapper
  import idm_pkg::*;
#(
  parameter int         RAM_BYTES = 128,
  parameter int         BANKS     = 4,
  parameter int         BANK_REGS = 8,
  parameter int         BANK_LSB  = 3,
  parameter logic [7:0] BIT_BASE  = 8'h20,
  parameter logic [7:0] SP_RESET  = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       req_write,
  input  logic       req_indirect,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [7:0] status_i,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic [7:0] rsp_data,
  output logic       sfr_stb,
  output logic       sfr_we,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata,
  output logic [7:0] sp_o
);
  localparam int AW = $clog2(RAM_BYTES);

  kind_e          kind;
  tgt_e           tgt;
  logic [AW-1:0]  ram_idx;
  logic [2:0]     bit_pos;
  logic           is_bit;
  logic [7:0]     ram_rd;
  logic [7:0]     ram_wd;
  logic           ram_we;
  logic           push, pop;

  assign kind = kind_e'(req_kind);
  assign push = req_valid && kind == K_STACK && req_write;
  assign pop  = req_valid && kind == K_STACK && !req_write;

  idm_decode #(
    .RAM_BYTES(RAM_BYTES), .BANKS(BANKS), .BANK_REGS(BANK_REGS),
    .BANK_LSB(BANK_LSB), .BIT_BASE(BIT_BASE)
  ) u_dec (
    .kind(kind), .indirect(req_indirect), .push(req_write),
    .addr(req_addr), .status(status_i), .sp(sp_o),
    .tgt(tgt), .ram_idx(ram_idx), .bit_pos(bit_pos), .is_bit(is_bit)
  );

  // Single-bit write merges into the byte read in the same cycle.
  always_comb begin
    ram_wd = req_wdata;
    if (is_bit) begin
      ram_wd          = ram_rd;
      ram_wd[bit_pos] = req_wdata[0];
    end
  end

  assign ram_we = req_valid && req_write && tgt == T_RAM;

  idm_ram #(.DEPTH(RAM_BYTES), .W(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_idx), .wdata(ram_wd), .rdata(ram_rd)
  );

  idm_stack #(.SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .sp(sp_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= 8'h00;
      sfr_stb   <= 1'b0;
      sfr_we    <= 1'b0;
      sfr_addr  <= 8'h00;
      sfr_wdata <= 8'h00;
    end else begin
      rsp_valid <= req_valid && tgt != T_SFR;
      rsp_err   <= req_valid && tgt == T_ERR;
      sfr_stb   <= req_valid && tgt == T_SFR;
      sfr_we    <= req_valid && tgt == T_SFR && req_write;
      if (req_valid && tgt == T_SFR) begin
        sfr_addr  <= req_addr;
        sfr_wdata <= req_wdata;
      end
      if (tgt == T_ERR)  rsp_data <= 8'h00;
      else if (is_bit)   rsp_data <= {7'b0, ram_rd[bit_pos]};
      else               rsp_data <= ram_rd;
    end
  end

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_valid, sfr_stb}));
  p_req_answered_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid || sfr_stb));
  p_sfr_upper_r6: assert property (@(posedge clk) disable iff (rst)
    sfr_stb |-> sfr_addr[7]);
  p_indirect_no_sfr_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_BYTE && req_indirect) |=> !sfr_stb);
  p_bitaddr_err_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_BIT && req_addr[7]) |=> (rsp_valid && rsp_err));
endmodule

// File: tb/sim_idata_mapper.sv
module sim_idata_mapper;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       req_write = 1'b0;
  logic       req_indirect = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic [7:0] status_i = 8'h00;
  logic       rsp_valid, rsp_err, sfr_stb, sfr_we;
  logic [7:0] rsp_data, sfr_addr, sfr_wdata, sp_o;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] KREG = 2'b00, KBIT = 2'b01, KBYTE = 2'b10, KSTK = 2'b11;

  idata_mapper u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_indirect(req_indirect), .req_addr(req_addr),
    .req_wdata(req_wdata), .status_i(status_i), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .sfr_stb(sfr_stb), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sp_o(sp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic req(logic [1:0] k, logic w, logic ind, logic [7:0] a,
                     logic [7:0] d, logic [7:0] st);
    req_valid = 1'b1; req_kind = k; req_write = w; req_indirect = ind;
    req_addr = a; req_wdata = d; status_i = st;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_byte(string tag, logic [7:0] a, logic [7:0] exp);
    req(KBYTE, 1'b0, 1'b0, a, 8'h00, 8'h00);
    chk(tag, rsp_data, exp);
  endtask

  task automatic t_reset();
    chk("R9 sp reset", sp_o, 8'h07);
    chk("R10 no rsp after reset", {7'b0, rsp_valid}, 8'h00);
    chk("R10 no sfr after reset", {7'b0, sfr_stb}, 8'h00);
  endtask

  task automatic t_stack();
    req(KSTK, 1'b1, 1'b0, 8'h00, 8'hAB, 8'h00);
    chk("R9 sp after push", sp_o, 8'h08);
    req(KSTK, 1'b1, 1'b0, 8'h00, 8'hCD, 8'h00);
    chk("R9 sp second push", sp_o, 8'h09);
    rd_byte("R9 first push at 08", 8'h08, 8'hAB);
    req(KSTK, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R9 pop data", rsp_data, 8'hCD);
    chk("R9 sp after pop", sp_o, 8'h08);
    req(KSTK, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R9 pop data 2", rsp_data, 8'hAB);
    chk("R9 sp back", sp_o, 8'h07);
    idle();
  endtask

  task automatic t_banks();
    req(KREG, 1'b1, 1'b0, 8'h04, 8'h11, 8'h00);
    rd_byte("R1 bank0 R4 at 04", 8'h04, 8'h11);
    req(KREG, 1'b1, 1'b0, 8'h04, 8'hA5, 8'h18);
    rd_byte("R1 bank3 R4 at 1C", 8'h1C, 8'hA5);
    req(KREG, 1'b0, 1'b0, 8'h04, 8'h00, 8'hE7);
    chk("R1 other status bits ignored", rsp_data, 8'h11);
    req(KREG, 1'b1, 1'b0, 8'h07, 8'h3E, 8'h18);
    rd_byte("R1 last reg at 1F", 8'h1F, 8'h3E);
    idle();
  endtask

  task automatic t_bank_switch();
    req(KREG, 1'b1, 1'b0, 8'h01, 8'h31, 8'h08);
    req(KREG, 1'b1, 1'b0, 8'h01, 8'h42, 8'h10);
    rd_byte("R2 bank1 R1 at 09", 8'h09, 8'h31);
    rd_byte("R2 bank2 R1 at 11", 8'h11, 8'h42);
    idle();
  endtask

  task automatic t_direct();
    req(KBYTE, 1'b1, 1'b0, 8'h7F, 8'h5C, 8'h00);
    req(KBYTE, 1'b0, 1'b0, 8'h7F, 8'h00, 8'h00);
    chk("R5 direct read 7F", rsp_data, 8'h5C);
    chk("R5 rsp_valid", {7'b0, rsp_valid}, 8'h01);
    chk("R5 no err", {7'b0, rsp_err}, 8'h00);
    chk("R10 no sfr on RAM access", {7'b0, sfr_stb}, 8'h00);
    idle();
  endtask

  task automatic t_sfr();
    req(KBYTE, 1'b1, 1'b0, 8'h19, 8'h77, 8'h00);
    req(KBYTE, 1'b1, 1'b0, 8'h99, 8'h01, 8'h00);
    chk("R6 sfr_stb", {7'b0, sfr_stb}, 8'h01);
    chk("R6 sfr_we", {7'b0, sfr_we}, 8'h01);
    chk("R6 sfr_addr", sfr_addr, 8'h99);
    chk("R6 sfr_wdata", sfr_wdata, 8'h01);
    chk("R10 no rsp on sfr", {7'b0, rsp_valid}, 8'h00);
    rd_byte("R6 RAM 19 untouched", 8'h19, 8'h77);
    req(KBYTE, 1'b0, 1'b0, 8'hF0, 8'h00, 8'h00);
    chk("R6 sfr read strobe", {sfr_we, sfr_stb}, 8'h01);
    chk("R6 sfr read addr", sfr_addr, 8'hF0);
    idle();
  endtask

  task automatic t_bits();
    req(KBYTE, 1'b1, 1'b0, 8'h20, 8'hFF, 8'h00);
    req(KBIT, 1'b0, 1'b0, 8'h05, 8'h00, 8'h00);
    chk("R3 bit 05 read set", rsp_data, 8'h01);
    req(KBIT, 1'b1, 1'b0, 8'h05, 8'hFE, 8'h00);
    rd_byte("R4 byte 20 after clear bit 05", 8'h20, 8'hDF);
    req(KBIT, 1'b0, 1'b0, 8'h05, 8'h00, 8'h00);
    chk("R3 bit 05 read clear", rsp_data, 8'h00);
    req(KBYTE, 1'b1, 1'b0, 8'h2F, 8'h00, 8'h00);
    req(KBIT, 1'b1, 1'b0, 8'h7F, 8'h01, 8'h00);
    rd_byte("R4 bit 7F in byte 2F", 8'h2F, 8'h80);
    req(KBYTE, 1'b1, 1'b0, 8'h21, 8'h00, 8'h00);
    req(KBIT, 1'b1, 1'b0, 8'h08, 8'h01, 8'h00);
    req(KBIT, 1'b1, 1'b0, 8'h09, 8'h01, 8'h00);
    rd_byte("R4 back-to-back bit writes", 8'h21, 8'h03);
    idle();
  endtask

  task automatic t_indirect();
    req(KBYTE, 1'b1, 1'b0, 8'h05, 8'h66, 8'h00);
    req(KBYTE, 1'b1, 1'b1, 8'h85, 8'h99, 8'h00);
    chk("R7 indirect 85 err", {6'b0, rsp_valid, rsp_err}, 8'h03);
    chk("R7 indirect not sfr", {7'b0, sfr_stb}, 8'h00);
    rd_byte("R7 RAM 05 untouched", 8'h05, 8'h66);
    req(KBYTE, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h00);
    chk("R7 indirect 7F data", rsp_data, 8'h5C);
    chk("R7 indirect 7F no err", {7'b0, rsp_err}, 8'h00);
    idle();
  endtask

  task automatic t_bit_err();
    req(KBIT, 1'b1, 1'b0, 8'h85, 8'h01, 8'h00);
    chk("R8 bit addr 85 err", {6'b0, rsp_valid, rsp_err}, 8'h03);
    rd_byte("R8 byte 20 untouched", 8'h20, 8'hDF);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stack();
    t_banks();
    t_bank_switch();
    t_direct();
    t_sfr();
    t_bits();
    t_indirect();
    t_bit_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule